// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps a 32-bit floating-point status word up to date as arithmetic operations complete. Each completed operation presents a 5-bit exception flag vector together with a one-cycle valid strobe. The block checks those flags against a trap-enable mask that software has loaded into the status word, and decides whether the operation traps. On a trap it narrows the enabled flags to a single flag by fixed priority, records only that flag as the current exception, leaves the accrued field alone, marks the trap type and raises a one-cycle trap pulse. Without a trap, every raised flag becomes the current exception and is also merged into the accrued field.

Software sets up and clears the word through a full-width write port. The block does not compute any arithmetic. It only turns a flag vector into status updates and a trap decision.

Top module: `fp_status_rec`

## Requirements
- R1: Field layout. The trap-enable mask is bits 27:23, the accrued field is bits 9:5 and the current field is bits 4:0. Inside each 5-bit field, bit 4 = invalid, bit 3 = overflow, bit 2 = underflow, bit 1 = divide-by-zero and bit 0 = inexact.
- R2: An accepted nonzero flag vector traps when its bitwise AND with the enable mask is nonzero. `trap_o` is high for exactly one cycle, and it is registered on the same edge that updates the status word.
- R3: On a trap, the flags are ANDed with the mask. If more than one bit survives, only the highest-priority bit is kept. The priority order is invalid, then overflow, then underflow, then divide-by-zero, then inexact.
- R4: For every accepted nonzero flag vector, the current field is overwritten with the resulting vector and is never ORed with its old value. Without a trap, that resulting vector is the full incoming flag vector.
- R5: The accrued field is ORed with the incoming flags only when no trap is taken. On a trap it keeps its old value.
- R6: On a trap, bit 14 (trap type: IEEE exception) is set. Bit 14 and every bit outside the three fields keep their old value otherwise.
- R7: A strobe carrying an all-zero flag vector leaves the whole status word unchanged and gives no trap pulse.
- R8: When `wr_en_i` is high, the whole word is loaded from `wr_data_i` on the next edge. A flag strobe in that same cycle is dropped and gives no trap.
- R9: Reset clears the status word and the trap output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_vld_i | input | 1 | Strobe: one operation completed |
| exc_flags_i | input | 5 | Exception flags of that operation |
| wr_en_i | input | 1 | Software write of the status word |
| wr_data_i | input | 32 | Value to write |
| status_o | output | 32 | Current status word |
| trap_o | output | 1 | One-cycle trap pulse |

## Verification
The bench builds the block with its default layout: a 32-bit word with the fields at bits 27:23, 9:5 and 4:0, and the trap-type bit at 14. With 5-bit fields, every pairing of enable mask and flag vector is only 1024 cases. The bench therefore sweeps all of them, each starting from a preset word whose accrued, current and unrelated bits carry distinct patterns. This exercises every priority collision, every mix of enabled and disabled flags, and the all-zero vector. Separate sequences cover the collision between a software write and a flag strobe, the width of the trap pulse, and a sticky trap-type bit.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int EXC_W = 5;
  typedef logic [EXC_W-1:0] exc_t;

  // Bit positions inside every exception field
  localparam int EXC_INVALID  = 4;
  localparam int EXC_OVERFLOW = 3;
  localparam int EXC_UNDERFL  = 2;
  localparam int EXC_DIVZERO  = 1;
  localparam int EXC_INEXACT  = 0;

  // Accrual merge: used only on non-trapping updates
  function automatic exc_t acc_merge(exc_t old_acc, exc_t fresh);
    return old_acc | fresh;
  endfunction

  // Flags that can cause a trap
  function automatic exc_t enabled_flags(exc_t flags, exc_t mask);
    return flags & mask;
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] pick_o
);
  // Higher index means higher priority; keep a bit only when nothing above it is set
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign pick_o[i] = req_i[i];
    end else begin : g_low
      assign pick_o[i] = req_i[i] & ~(|req_i[W-1:i+1]);
    end
  end
endmodule

// File: rtl/exc_trap_eval.sv
module exc_trap_eval
  import fpsr_pkg::*;
(
  input  exc_t flags_i,
  input  exc_t mask_i,
  input  exc_t acc_q_i,
  output logic any_o,
  output logic trap_o,
  output exc_t cur_nxt_o,
  output exc_t acc_nxt_o
);
  exc_t hit;
  exc_t single;

  assign hit   = enabled_flags(flags_i, mask_i);
  assign any_o = |flags_i;
  assign trap_o = |hit;

  exc_prio_pick #(.W(EXC_W)) u_pick (
    .req_i  (hit),
    .pick_o (single)
  );

  assign cur_nxt_o = trap_o ? single : flags_i;
  assign acc_nxt_o = trap_o ? acc_q_i : acc_merge(acc_q_i, flags_i);
endmodule

// File: rtl/fpsr_store.sv
module fpsr_store
  import fpsr_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int MASK_LSB = 23,
  parameter int ACC_LSB  = 5,
  parameter int CUR_LSB  = 0,
  parameter int TT_BIT   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             upd_i,
  input  logic             trap_i,
  input  exc_t             cur_i,
  input  exc_t             acc_i,
  output logic [REG_W-1:0] q_o,
  output logic             trap_q_o
);
  logic [REG_W-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (wr_en_i) begin
      nxt = wr_data_i;
    end else if (upd_i) begin
      nxt[CUR_LSB +: EXC_W] = cur_i;
      nxt[ACC_LSB +: EXC_W] = acc_i;
      if (trap_i) nxt[TT_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o      <= '0;
      trap_q_o <= 1'b0;
    end else begin
      q_o      <= nxt;
      trap_q_o <= upd_i & trap_i;
    end
  end
endmodule

// File: rtl/fp_status_rec.sv
module fp_status_rec
  import fpsr_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int MASK_LSB = 23,
  parameter int ACC_LSB  = 5,
  parameter int CUR_LSB  = 0,
  parameter int TT_BIT   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_vld_i,
  input  logic [4:0]       exc_flags_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] status_o,
  output logic             trap_o
);
  // Named internal events
  exc_t ev_mask;
  exc_t ev_acc_q;
  exc_t ev_cur_nxt;
  exc_t ev_acc_nxt;
  logic ev_any;
  logic ev_trap;
  logic ev_update;

  assign ev_mask   = status_o[MASK_LSB +: EXC_W];
  assign ev_acc_q  = status_o[ACC_LSB +: EXC_W];
  assign ev_update = exc_vld_i & ~wr_en_i & ev_any;

  exc_trap_eval u_eval (
    .flags_i   (exc_flags_i),
    .mask_i    (ev_mask),
    .acc_q_i   (ev_acc_q),
    .any_o     (ev_any),
    .trap_o    (ev_trap),
    .cur_nxt_o (ev_cur_nxt),
    .acc_nxt_o (ev_acc_nxt)
  );

  fpsr_store #(
    .REG_W(REG_W), .MASK_LSB(MASK_LSB), .ACC_LSB(ACC_LSB),
    .CUR_LSB(CUR_LSB), .TT_BIT(TT_BIT)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .upd_i     (ev_update),
    .trap_i    (ev_trap),
    .cur_i     (ev_cur_nxt),
    .acc_i     (ev_acc_nxt),
    .q_o       (status_o),
    .trap_q_o  (trap_o)
  );
endmodule

// File: rtl/fp_status_rec_chk.sv
module fp_status_rec_chk #(
  parameter int REG_W    = 32,
  parameter int MASK_LSB = 23,
  parameter int ACC_LSB  = 5,
  parameter int CUR_LSB  = 0,
  parameter int TT_BIT   = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exc_vld_i,
  input logic [4:0]       exc_flags_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] status_o,
  input logic             trap_o
);
  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(exc_vld_i && !wr_en_i && ((exc_flags_i & status_o[MASK_LSB +: 5]) != 5'd0))); // R2
  AST_TRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($countones(status_o[CUR_LSB +: 5]) == 1)); // R3
  AST_ACC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (status_o[ACC_LSB +: 5] == $past(status_o[ACC_LSB +: 5]))); // R5
  AST_TT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> status_o[TT_BIT]); // R6
  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(exc_vld_i && exc_flags_i != 5'd0)) |=> $stable(status_o)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !trap_o); // R8
endmodule

bind fp_status_rec fp_status_rec_chk #(
  .REG_W(REG_W), .MASK_LSB(MASK_LSB), .ACC_LSB(ACC_LSB),
  .CUR_LSB(CUR_LSB), .TT_BIT(TT_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_vld_i   (exc_vld_i),
  .exc_flags_i (exc_flags_i),
  .wr_en_i     (wr_en_i),
  .status_o    (status_o),
  .trap_o      (trap_o)
);

// File: tb/fp_status_rec_tb_top.sv
module fp_status_rec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [4:0]  flags = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] stat;
  logic        trap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  fp_status_rec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exc_vld_i(vld), .exc_flags_i(flags),
    .wr_en_i(wr), .wr_data_i(wdata), .status_o(stat), .trap_o(trap)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic strobe(input logic [4:0] f);
    @(negedge clk); vld = 1'b1; flags = f;
    @(negedge clk); vld = 1'b0; flags = '0;
  endtask

  // Highest set index wins (invalid=4 ... inexact=0)
  function automatic logic [4:0] top_bit(input logic [4:0] v);
    logic [4:0] r = '0;
    for (int b = 0; b < 5; b++) if (v[b]) r = 5'd1 << b;
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(stat == 32'd0 && trap == 1'b0, "R9 reset", {stat[31:1], trap}, 32'd0);
    rst_n = 1'b1;

    // Exhaustive sweep of mask x flags
    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        logic [4:0]  mk = m[4:0];
        logic [4:0]  fl = f[4:0];
        logic [4:0]  accp = 5'((m * 3 + 1) & 31);
        logic [4:0]  curp = ~fl;
        logic [31:0] pre = 32'h4002_8800 | ({27'd0, mk} << 23) | ({27'd0, accp} << 5) | {27'd0, curp};
        logic [31:0] exp = pre;
        logic        etrap = 1'b0;
        logic [4:0]  hit = fl & mk;
        write_word(pre);
        strobe(fl);
        if (fl != 5'd0) begin
          if (hit != 5'd0) begin
            etrap = 1'b1;
            exp[4:0] = top_bit(hit);
            exp[14] = 1'b1;
          end else begin
            exp[4:0] = fl;
            exp[9:5] = accp | fl;
          end
        end
        if (fl == 5'd0)
          chk(stat == exp && trap == 1'b0, "R7 zero flags", stat, exp);
        else if (etrap)
          chk(stat == exp, "R3 R5 R6 trap update", stat, exp);
        else
          chk(stat == exp, "R1 R4 R5 accrue update", stat, exp);
        chk(trap == etrap, "R2 trap decision", {31'd0, trap}, {31'd0, etrap});
      end
    end

    // R2: trap pulse lasts one cycle
    write_word(32'h0800_0000);          // enable invalid only
    strobe(5'b10000);
    chk(trap == 1'b1, "R2 pulse high", {31'd0, trap}, 32'd1);
    @(negedge clk);
    chk(trap == 1'b0, "R2 pulse one cycle", {31'd0, trap}, 32'd0);

    // R8: write and flag strobe in the same cycle
    write_word(32'h0F80_0000);
    @(negedge clk); wr = 1'b1; wdata = 32'h0F80_0123; vld = 1'b1; flags = 5'b11111;
    @(negedge clk); wr = 1'b0; vld = 1'b0; flags = '0;
    chk(stat == 32'h0F80_0123, "R8 write wins", stat, 32'h0F80_0123);
    chk(trap == 1'b0, "R8 no trap on collision", {31'd0, trap}, 32'd0);

    // R6: sticky trap-type bit survives a non-trapping update
    write_word(32'h0000_4000);
    strobe(5'b00001);
    chk(stat == 32'h0000_4021, "R6 bit14 kept", stat, 32'h0000_4021);

    // R4: current field replaced, not ORed, across two updates
    write_word(32'h0);
    strobe(5'b00011);
    strobe(5'b00100);
    chk(stat == 32'h0000_00E4, "R4 replace", stat, 32'h0000_00E4);

    done = 1'b1;
  end

  initial begin
    bit hung = 1'b1;
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) begin hung = 1'b0; break; end
    end
    if (hung) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule